// File: doc/BRIEF.md
# Two-Register Bus Configuration Target

This block is a target on a two-wire serial bus (I2C) that holds two 8-bit control registers for a low-speed signal router. A routing register at index 0 carries the bank-enable and bank-select settings. A pin-control register at index 1 sets four general-purpose outputs. Each of those outputs can be driven low, driven high or left floating, and each is brought out as a value and an output-enable pair.

The serial clock and data lines are sampled with the system clock, which must run at least 20 times faster than the serial clock (100 kHz to 400 kHz). Start and stop conditions are found from data edges while the clock is high. The target answers to a 7-bit address whose three low bits come from strap inputs. After the address, a write places a register pointer and then data bytes. A read may follow the pointer write through a repeated start.

A mode input selects register control. While it is low, the block stays off the bus and holds every output enable off.

Top module: `cfgt_top`

## Requirements
- R1: The target acknowledges, by pulling data low during the 9th clock, only the address whose upper four bits are 0111 and whose lower three bits equal the straps, with the strap's bit 0 as the address LSB. Any other address gets no acknowledge, and the following bytes change nothing.
- R2: After reset the routing register reads 0x00 and the pin-control register reads 0xAA, so all four output enables are off.
- R3: Bits [1:0] of the routing register always read 0, whatever value is written to them.
- R4: In the pin-control register, pin n is controlled by bits [2n+1:2n]. A field of 00 drives the pin low (enable 1, value 0), 01 drives it high (enable 1, value 1), and 1x floats it (enable 0, value 0).
- R5: The first byte written after the address is a register pointer, and only its bit 0 selects the register (0 = routing, 1 = pin-control).
- R6: Each further data byte written goes to the pointed register, and the pointer then toggles. During a read, the pointer also toggles after each byte.
- R7: A repeated start with the read bit (address LSB = 1) returns the pointed register, MSB first, without any stop after the pointer write.
- R8: When the controller NACKs a read byte, the target releases data and waits for the next start. A stop ends any transfer.
- R9: While mode is 0, the target never pulls data and never acknowledges, and all output enables are 0. The register contents are kept.
- R10: The routing output equals the routing register, including its two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = register control active, 0 = bus ignored and outputs floated |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Low three address bits |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| route_o | output | 8 | Routing register contents |
| pin_val_o | output | 4 | Output value per general-purpose pin |
| pin_oe_o | output | 4 | Output enable per general-purpose pin |

## Verification
The assertions assume the controller follows the bus rules. Data changes only while the serial clock is low, except for start and stop. The controller never issues a stop or a start while the target is acknowledging or driving a data bit. Mode changes only while the bus is idle. The bench models an open-drain controller that holds every data change a quarter of a serial period away from the clock edges. It uses a serial clock 40 system cycles long, and it toggles mode and straps only between transfers, so the stimulus stays inside these assumptions.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;
  localparam int BYTE_W   = 8;
  localparam int STRAP_W  = 3;
  localparam int CNT_W    = 4;
  localparam int NUM_PINS = BYTE_W / 2;
  localparam logic [BYTE_W-STRAP_W-2:0] ADDR_FIXED = 4'b0111;
  localparam logic [BYTE_W-1:0] RST_ROUTE  = 8'h00;
  localparam logic [BYTE_W-1:0] RST_PINCTL = 8'hAA;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } bus_st_e;
endpackage

// File: rtl/cfgt_line_sync.sv
module cfgt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/cfgt_bus_fsm.sv
module cfgt_bus_fsm
  import cfgt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               scl_lvl_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               sda_lvl_i,
  input  logic               sda_rise_i,
  input  logic               sda_fall_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic               wr_en_o,
  output logic               wr_sel_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               rd_sel_o
);
  bus_st_e            state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  shreg_q;
  logic               is_addr_q, rw_q, ptr_phase_q, ptr_q, mack_q, pull_q;
  logic               start_det, stop_det;

  assign start_det = scl_lvl_i & sda_fall_i;
  assign stop_det  = scl_lvl_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      shreg_q     <= '0;
      is_addr_q   <= 1'b0;
      rw_q        <= 1'b0;
      ptr_phase_q <= 1'b0;
      ptr_q       <= 1'b0;
      mack_q      <= 1'b0;
      pull_q      <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_sel_o    <= 1'b0;
      wr_data_o   <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (!mode_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_det) begin
        state_q     <= ST_RX;
        cnt_q       <= '0;
        is_addr_q   <= 1'b1;
        ptr_phase_q <= 1'b1;
        pull_q      <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != CNT_W'(BYTE_W)) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              if (is_addr_q) begin
                if (shreg_q[BYTE_W-1:1] == {ADDR_FIXED, strap_i}) begin
                  pull_q  <= 1'b1;
                  rw_q    <= shreg_q[0];
                  state_q <= ST_RX_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                pull_q  <= 1'b1;
                state_q <= ST_RX_ACK;
                if (ptr_phase_q) begin
                  ptr_q       <= shreg_q[0];
                  ptr_phase_q <= 1'b0;
                end else begin
                  wr_en_o   <= 1'b1;
                  wr_sel_o  <= ptr_q;
                  wr_data_o <= shreg_q;
                  ptr_q     <= ~ptr_q;
                end
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              cnt_q     <= '0;
              is_addr_q <= 1'b0;
              if (is_addr_q && rw_q) begin
                state_q <= ST_TX;
                shreg_q <= rd_data_i;
                pull_q  <= ~rd_data_i[BYTE_W-1];
              end else begin
                state_q <= ST_RX;
                pull_q  <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_W'(BYTE_W-1)) begin
                pull_q  <= 1'b0;
                ptr_q   <= ~ptr_q;
                state_q <= ST_TX_ACK;
              end else begin
                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                pull_q  <= ~shreg_q[BYTE_W-2];
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_lvl_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                state_q <= ST_TX;
                cnt_q   <= '0;
                shreg_q <= rd_data_i;
                pull_q  <= ~rd_data_i[BYTE_W-1];
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign rd_sel_o   = ptr_q;

  // R1: the target moves the data line only while the clock is low
  assert_sda_change_scl_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(pull_q) && $past(mode_i) && !$past(start_det) && !$past(stop_det))
      |-> !$past(scl_lvl_i));

  assert_ptr_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (ptr_q != $past(ptr_q)));

  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && mode_i) |=> (state_q == ST_IDLE && !pull_q));
endmodule

// File: rtl/cfgt_regs.sv
module cfgt_regs
  import cfgt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic                rd_sel_i,
  output logic [BYTE_W-1:0]   rd_data_o,
  output logic [BYTE_W-1:0]   route_o,
  output logic [NUM_PINS-1:0] pin_val_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  logic [BYTE_W-1:2] route_q;
  logic [BYTE_W-1:0] pinctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q  <= RST_ROUTE[BYTE_W-1:2];
      pinctl_q <= RST_PINCTL;
    end else if (wr_en_i) begin
      if (wr_sel_i) pinctl_q <= wr_data_i;
      else          route_q  <= wr_data_i[BYTE_W-1:2];
    end
  end

  // low two routing bits are hardwired zero
  assign route_o   = {route_q, 2'b00};
  assign rd_data_o = rd_sel_i ? pinctl_q : route_o;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_oe_o[p]  = mode_i & ~pinctl_q[2*p+1];
    assign pin_val_o[p] = pin_oe_o[p] & pinctl_q[2*p];
  end

  assert_wr_route_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (route_o[BYTE_W-1:2] == $past(wr_data_i[BYTE_W-1:2])));

  assert_wr_pin0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i) |=> (!mode_i || pin_oe_o[0] == !$past(wr_data_i[1])));
endmodule

// File: rtl/cfgt_top.sv
module cfgt_top
  import cfgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [STRAP_W-1:0]  strap_i,
  output logic                sda_pull_o,
  output logic [BYTE_W-1:0]   route_o,
  output logic [NUM_PINS-1:0] pin_val_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  logic wr_en, wr_sel, rd_sel;
  logic [BYTE_W-1:0] wr_data, rd_data;

  cfgt_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  cfgt_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  cfgt_bus_fsm u_fsm (
    .clk_i, .rst_ni, .mode_i,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .strap_i, .rd_data_i(rd_data),
    .sda_pull_o, .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
    .rd_sel_o(rd_sel));

  cfgt_regs u_regs (
    .clk_i, .rst_ni, .mode_i,
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .route_o, .pin_val_o, .pin_oe_o);

  assert_quiet_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> !sda_pull_o);
endmodule

// File: tb/tb_cfgt_top.sv
module tb_cfgt_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_pull;
  logic [7:0] route;
  logic [3:0] pin_val, pin_oe;
  logic       sda_line;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       done = 1'b0;

  assign sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  cfgt_top dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_pull_o(sda_pull), .route_o(route),
    .pin_val_o(pin_val), .pin_oe_o(pin_oe));

  // {pointer byte, data byte}
  localparam logic [15:0] VEC [0:7] = '{
    16'h00FF, 16'h0100, 16'h025A, 16'hFF1B,
    16'h0003, 16'h01E4, 16'h8155, 16'h00A7 };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [3:0] exp_oe(input logic [7:0] d);
    for (int i = 0; i < 4; i++) exp_oe[i] = ~d[2*i+1];
  endfunction

  function automatic logic [3:0] exp_val(input logic [7:0] d);
    for (int i = 0; i < 4; i++) exp_val[i] = ~d[2*i+1] & d[2*i];
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic wr_seq(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d0,
                        input logic [7:0] d1, input int n, output logic ok);
    logic k0, k1, k2, k3;
    k2 = 1'b1; k3 = 1'b1;
    bus_start();
    put_byte({a, 1'b0}, k0);
    put_byte(p, k1);
    if (n > 0) put_byte(d0, k2);
    if (n > 1) put_byte(d1, k3);
    bus_stop();
    ok = k0 & k1 & k2 & k3;
  endtask

  task automatic rd_seq(input logic [6:0] a, input logic [7:0] p, input int n,
                        output logic [7:0] r0, output logic [7:0] r1, output logic ok);
    logic k0, k1, k2;
    r1 = 8'h00;
    bus_start();
    put_byte({a, 1'b0}, k0);
    put_byte(p, k1);
    bus_start();
    put_byte({a, 1'b1}, k2);
    get_byte(n > 1, r0);
    if (n > 1) get_byte(1'b0, r1);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [6:0] dev;
    logic [7:0] r0, r1, e;
    logic       ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    dev = {4'b0111, strap};

    // R2 reset state
    chk("R2 route reset", route, 8'h00);
    chk("R2 oe reset", pin_oe, 4'h0);
    chk("R2 val reset", pin_val, 4'h0);
    chk("R8 idle pull", sda_pull, 1'b0);
    // R7 repeated-start read, R6 toggle on read
    rd_seq(dev, 8'h00, 2, r0, r1, ok);
    chk("R1 ack on own address", ok, 1'b1);
    chk("R7 read reg0 reset", r0, 8'h00);
    chk("R6 read toggles to reg1 reset", r1, 8'hAA);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [7:0] p, d;
      p = VEC[v][15:8];
      d = VEC[v][7:0];
      e = p[0] ? d : (d & 8'hFC);  // R3 low bits zero, R5 pointer bit 0
      wr_seq(dev, p, d, 8'h00, 1, ok);
      chk("R1 write acked", ok, 1'b1);
      rd_seq(dev, p, 1, r0, r1, ok);
      chk("R5 R3 readback", r0, e);
      if (p[0]) begin
        chk("R4 pin oe", pin_oe, exp_oe(d));
        chk("R4 pin val", pin_val, exp_val(d));
      end else begin
        chk("R10 route out", route, e);
      end
      chk("R8 released after nack", sda_pull, 1'b0);
    end

    // R6 two-byte write with toggle
    wr_seq(dev, 8'h00, 8'h6F, 8'h50, 2, ok);
    chk("R6 burst acked", ok, 1'b1);
    chk("R6 route first byte", route, 8'h6C);
    chk("R6 oe second byte", pin_oe, 4'hF);
    chk("R6 val second byte", pin_val, 4'hC);
    rd_seq(dev, 8'h01, 2, r0, r1, ok);
    chk("R6 read reg1 then reg0 a", r0, 8'h50);
    chk("R6 read reg1 then reg0 b", r1, 8'h6C);

    // R1 wrong addresses ignored
    wr_seq({4'b0111, ~strap}, 8'h00, 8'h10, 8'h00, 1, ok);
    chk("R1 strap mismatch nack", ok, 1'b0);
    chk("R1 route unchanged", route, 8'h6C);
    wr_seq({4'b1111, strap}, 8'h00, 8'h20, 8'h00, 1, ok);
    chk("R1 fixed mismatch nack", ok, 1'b0);
    chk("R1 route unchanged 2", route, 8'h6C);

    // R9 mode 0
    mode = 1'b0;
    wq();
    chk("R9 oe off in mode 0", pin_oe, 4'h0);
    chk("R9 val off in mode 0", pin_val, 4'h0);
    wr_seq(dev, 8'h00, 8'h44, 8'h00, 1, ok);
    chk("R9 no ack in mode 0", ok, 1'b0);
    chk("R9 route kept", route, 8'h6C);
    mode = 1'b1;
    wq();
    chk("R9 oe back", pin_oe, 4'hF);

    // R1 new strap value
    strap = 3'b010;
    wq();
    wr_seq({4'b0111, 3'b010}, 8'h01, 8'h9D, 8'h00, 1, ok);
    chk("R1 new strap acked", ok, 1'b1);
    chk("R4 oe 9D", pin_oe, exp_oe(8'h9D));
    chk("R4 val 9D", pin_val, exp_val(8'h9D));
    wr_seq(dev, 8'h00, 8'h00, 8'h00, 1, ok);
    chk("R1 old address nack", ok, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule